// File: doc/BRIEF.md
# Dual-Port Readout Arbitration Controller

This block sits beside the readout sequencer of a 16-channel digitizer. After each conversion it decides which readout path runs: a fast parallel port, a slow dataway bus port, or both, one after the other. The fast port always goes first when it is enabled. While a path is active, the block hands the shared sequencer the compression and pedestal mode bits that belong to that path.

A 16-bit command register holds an enable, a compression select and a pedestal select for each port. A bus command interface writes it with function code 16 at subaddress 0 and reads it with function code 0 at subaddress 0. The register can be accessed only while no readout is running. A clear command puts the register back to its default value and aborts any readout in progress.

The sequencing is a state machine with three states:
- `ST_READY`: neither readout is active.
- `ST_FAST`: the fast-port readout is active.
- `ST_BUS`: the bus readout is active.

It has five transitions:
- `EOC_TO_FAST`: end of conversion while the fast enable is on.
- `EOC_TO_BUS`: end of conversion while the fast enable is off.
- `FAST_TO_BUS`: end of the fast-port readout.
- `BUS_TO_READY`: end of the bus readout.
- `CLEAR_ABORT`: a clear command, from any state, back to `ST_READY`.

Top module: `ro_arbiter`

## Requirements
- R1: After reset the block is in ready (`ready_o`=1, `fast_active_o`=0, `bus_active_o`=0, mode outputs 0). The register holds 0x0707.
- R2: The register layout is: bit0 fast enable, bit1 fast compression, bit2 fast pedestal, bit8 bus enable, bit9 bus compression, bit10 bus pedestal. All other bits are plain storage.
  - A command with `cmd_func_i`=16 and `cmd_addr_i`=0 writes `cmd_wdata_i`.
  - A command with `cmd_func_i`=0 and `cmd_addr_i`=0 reads. At the next clock edge `rd_valid_o` is 1 for one cycle and `rd_data_o` holds the register value.
  - Any other function code or subaddress is ignored.
- R3: Writes and reads are accepted only in ready. Otherwise a write leaves the register unchanged and a read raises no `rd_valid_o`.
- R4: End of conversion in ready with bit0 set makes `fast_active_o` 1 from the next cycle on.
- R5: End of conversion in ready with bit0 clear makes `bus_active_o` 1 from the next cycle on.
- R6: `fast_done_i` in `ST_FAST` moves the block to `ST_BUS` at the next edge. Strobes that do not match the current state have no effect.
- R7: `bus_done_i` in `ST_BUS` returns the block to ready at the next edge.
- R8: The mode outputs depend on the state:
  - In `ST_FAST`, `seq_comp_o` is bit1 and `seq_ped_o` is bit2.
  - In `ST_BUS`, `seq_comp_o` is bit9 AND bit8, and `seq_ped_o` is bit10.
  - In ready, both are 0.
- R9: `clr_i` has priority over every other input. From any state, it returns the block to ready at the next edge and loads the register with 0x0707.
- R10: At any time exactly one of `ready_o`, `fast_active_o` and `bus_active_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eoc_i | input | 1 | End-of-conversion strobe |
| fast_done_i | input | 1 | End of fast-port readout strobe |
| bus_done_i | input | 1 | End of bus readout strobe |
| clr_i | input | 1 | Clear command |
| cmd_valid_i | input | 1 | Bus command strobe |
| cmd_func_i | input | 5 | Bus function code |
| cmd_addr_i | input | 4 | Bus subaddress |
| cmd_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle |
| rd_data_o | output | 16 | Read data |
| ready_o | output | 1 | No readout active |
| fast_active_o | output | 1 | Fast-port readout active |
| bus_active_o | output | 1 | Bus readout active |
| seq_comp_o | output | 1 | Compression select to sequencer |
| seq_ped_o | output | 1 | Pedestal select to sequencer |

## Verification
The hardest case to reach is a write attempted during a readout. Its only trace is the absence of a change, and that can be seen only after the block has walked back to ready and a read is issued. The stimulus therefore loads a distinctive pattern, starts a chained fast-then-bus readout, tries a zero write and a read mid-readout, completes both readouts, and then reads the pattern back. Clear is exercised in both active states and in the same cycle as a write and as an end of conversion, to confirm its priority.

// File: rtl/ro_arb_pkg.sv
`timescale 1ns/1ps
package ro_arb_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_FAST  = 2'd1,
        ST_BUS   = 2'd2
    } ro_state_e;

    localparam int BIT_FAST_EN   = 0;
    localparam int BIT_FAST_COMP = 1;
    localparam int BIT_FAST_PED  = 2;
    localparam int BIT_BUS_EN    = 8;
    localparam int BIT_BUS_COMP  = 9;
    localparam int BIT_BUS_PED   = 10;
    localparam int MIN_REG_W     = 11;
endpackage

// File: rtl/ro_cmd_reg.sv
`timescale 1ns/1ps
module ro_cmd_reg
    import ro_arb_pkg::*;
#(
    parameter int          DATA_W  = 16,
    parameter int          FUNC_W  = 5,
    parameter int          ADDR_W  = 4,
    parameter int          FN_WR   = 16,
    parameter int          FN_RD   = 0,
    parameter logic [DATA_W-1:0] CLR_VAL = 16'h0707
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              ready_i,
    input  logic              cmd_valid_i,
    input  logic [FUNC_W-1:0] cmd_func_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              fast_en_o,
    output logic              fast_comp_o,
    output logic              fast_ped_o,
    output logic              bus_en_o,
    output logic              bus_comp_o,
    output logic              bus_ped_o
);
    localparam logic [FUNC_W-1:0] WR_CODE = FUNC_W'(FN_WR);
    localparam logic [FUNC_W-1:0] RD_CODE = FUNC_W'(FN_RD);

    logic [DATA_W-1:0] cmd_q;
    logic              sub0;
    logic              wr_hit;
    logic              rd_hit;

    assign sub0   = (cmd_addr_i == '0);
    assign wr_hit = cmd_valid_i && ready_i && sub0 && (cmd_func_i == WR_CODE);
    assign rd_hit = cmd_valid_i && ready_i && sub0 && (cmd_func_i == RD_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CLR_VAL;
        end else if (clr_i) begin
            cmd_q <= CLR_VAL;
        end else if (wr_hit) begin
            cmd_q <= cmd_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_hit && !clr_i;
            if (rd_hit && !clr_i) begin
                rd_data_o <= cmd_q;
            end
        end
    end

    assign fast_en_o   = cmd_q[BIT_FAST_EN];
    assign fast_comp_o = cmd_q[BIT_FAST_COMP];
    assign fast_ped_o  = cmd_q[BIT_FAST_PED];
    assign bus_en_o    = cmd_q[BIT_BUS_EN];
    assign bus_comp_o  = cmd_q[BIT_BUS_COMP];
    assign bus_ped_o   = cmd_q[BIT_BUS_PED];

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_i && !clr_i) |=> $stable(cmd_q)); // R3
    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> !rd_valid_o); // R3
    AST_CLR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cmd_q == CLR_VAL)); // R9
endmodule

// File: rtl/ro_seq_fsm.sv
`timescale 1ns/1ps
module ro_seq_fsm
    import ro_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic eoc_i,
    input  logic fast_done_i,
    input  logic bus_done_i,
    input  logic fast_en_i,
    output logic ready_o,
    output logic fast_active_o,
    output logic bus_active_o
);
    ro_state_e state_q;
    ro_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = ST_READY;                       // CLEAR_ABORT
        end else begin
            unique case (state_q)
                ST_READY: if (eoc_i) state_d = fast_en_i ? ST_FAST : ST_BUS; // EOC_TO_FAST / EOC_TO_BUS
                ST_FAST:  if (fast_done_i) state_d = ST_BUS;                 // FAST_TO_BUS
                ST_BUS:   if (bus_done_i) state_d = ST_READY;                // BUS_TO_READY
                default:  state_d = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ready_o       = 1'b0;
        fast_active_o = 1'b0;
        bus_active_o  = 1'b0;
        unique case (state_q)
            ST_READY: ready_o       = 1'b1;
            ST_FAST:  fast_active_o = 1'b1;
            ST_BUS:   bus_active_o  = 1'b1;
            default:  ready_o       = 1'b1;
        endcase
    end

    AST_CLR_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ready_o); // R9
    AST_EOC_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && eoc_i && fast_en_i && !clr_i) |=> fast_active_o); // R4
    AST_EOC_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && eoc_i && !fast_en_i && !clr_i) |=> bus_active_o); // R5
    AST_FAST_TO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_active_o && fast_done_i && !clr_i) |=> bus_active_o); // R6
    AST_BUS_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active_o && bus_done_i && !clr_i) |=> ready_o); // R7
endmodule

// File: rtl/ro_mode_mux.sv
`timescale 1ns/1ps
module ro_mode_mux (
    input  logic fast_active_i,
    input  logic bus_active_i,
    input  logic fast_comp_i,
    input  logic fast_ped_i,
    input  logic bus_en_i,
    input  logic bus_comp_i,
    input  logic bus_ped_i,
    output logic seq_comp_o,
    output logic seq_ped_o
);
    always_comb begin
        seq_comp_o = 1'b0;
        seq_ped_o  = 1'b0;
        if (fast_active_i) begin
            seq_comp_o = fast_comp_i;
            seq_ped_o  = fast_ped_i;
        end else if (bus_active_i) begin
            seq_comp_o = bus_comp_i && bus_en_i;
            seq_ped_o  = bus_ped_i;
        end
    end

    always_comb begin
        AST_ONE_PATH: assert (!(fast_active_i && bus_active_i)); // R10
    end
endmodule

// File: rtl/ro_arbiter.sv
`timescale 1ns/1ps
module ro_arbiter
    import ro_arb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FUNC_W = 5,
    parameter int ADDR_W = 4,
    parameter int FN_WR  = 16,
    parameter int FN_RD  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eoc_i,
    input  logic              fast_done_i,
    input  logic              bus_done_i,
    input  logic              clr_i,
    input  logic              cmd_valid_i,
    input  logic [FUNC_W-1:0] cmd_func_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ready_o,
    output logic              fast_active_o,
    output logic              bus_active_o,
    output logic              seq_comp_o,
    output logic              seq_ped_o
);
    localparam logic [DATA_W-1:0] CLR_VAL =
        (DATA_W'(1) << BIT_FAST_EN)  | (DATA_W'(1) << BIT_FAST_COMP) |
        (DATA_W'(1) << BIT_FAST_PED) | (DATA_W'(1) << BIT_BUS_EN)    |
        (DATA_W'(1) << BIT_BUS_COMP) | (DATA_W'(1) << BIT_BUS_PED);

    logic fast_en, fast_comp, fast_ped, bus_en, bus_comp, bus_ped;

    ro_cmd_reg #(
        .DATA_W (DATA_W),
        .FUNC_W (FUNC_W),
        .ADDR_W (ADDR_W),
        .FN_WR  (FN_WR),
        .FN_RD  (FN_RD),
        .CLR_VAL(CLR_VAL)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .ready_i    (ready_o),
        .cmd_valid_i(cmd_valid_i),
        .cmd_func_i (cmd_func_i),
        .cmd_addr_i (cmd_addr_i),
        .cmd_wdata_i(cmd_wdata_i),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .fast_en_o  (fast_en),
        .fast_comp_o(fast_comp),
        .fast_ped_o (fast_ped),
        .bus_en_o   (bus_en),
        .bus_comp_o (bus_comp),
        .bus_ped_o  (bus_ped)
    );

    ro_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr_i),
        .eoc_i        (eoc_i),
        .fast_done_i  (fast_done_i),
        .bus_done_i   (bus_done_i),
        .fast_en_i    (fast_en),
        .ready_o      (ready_o),
        .fast_active_o(fast_active_o),
        .bus_active_o (bus_active_o)
    );

    ro_mode_mux u_mux (
        .fast_active_i(fast_active_o),
        .bus_active_i (bus_active_o),
        .fast_comp_i  (fast_comp),
        .fast_ped_i   (fast_ped),
        .bus_en_i     (bus_en),
        .bus_comp_i   (bus_comp),
        .bus_ped_i    (bus_ped),
        .seq_comp_o   (seq_comp_o),
        .seq_ped_o    (seq_ped_o)
    );

    initial begin
        AST_WIDTH_OK: assert (DATA_W >= MIN_REG_W); // R2
    end
endmodule

// File: tb/sim_ro_arbiter.sv
`timescale 1ns/1ps
module sim_ro_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eoc, fdone, bdone, clr, cv;
    logic [4:0]  func;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic        rd_valid, ready, fast_act, bus_act, comp, ped;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string       req;
        int          st;     // 0 ready, 1 fast, 2 bus
        logic        comp;
        logic        ped;
        logic        rv;
        logic [15:0] rd;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    ro_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .eoc_i(eoc), .fast_done_i(fdone),
        .bus_done_i(bdone), .clr_i(clr), .cmd_valid_i(cv), .cmd_func_i(func),
        .cmd_addr_i(addr), .cmd_wdata_i(wdata), .rd_valid_o(rd_valid),
        .rd_data_o(rd_data), .ready_o(ready), .fast_active_o(fast_act),
        .bus_active_o(bus_act), .seq_comp_o(comp), .seq_ped_o(ped)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle and compares
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "ready", 16'(ready), 16'(e.st == 0));
            chk(e.req, "fast",  16'(fast_act), 16'(e.st == 1));
            chk(e.req, "bus",   16'(bus_act), 16'(e.st == 2));
            chk(e.req, "comp",  16'(comp), 16'(e.comp));
            chk(e.req, "ped",   16'(ped), 16'(e.ped));
            chk(e.req, "rv",    16'(rd_valid), 16'(e.rv));
            if (e.rv) chk(e.req, "rdata", rd_data, e.rd);
            chk("R10", "onehot", 16'($countones({ready, fast_act, bus_act})), 16'd1);
        end
    end

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic cyc(input string req, input logic e_, input logic f_, input logic b_,
                       input logic c_, input logic v_, input logic [4:0] fn,
                       input logic [3:0] ad, input logic [15:0] wd, input int st,
                       input logic ec, input logic ep, input logic erv, input logic [15:0] erd);
        exp_t e;
        @(negedge clk);
        eoc = e_; fdone = f_; bdone = b_; clr = c_;
        cv = v_; func = fn; addr = ad; wdata = wd;
        @(posedge clk);
        #1;
        e.req = req; e.st = st; e.comp = ec; e.ped = ep; e.rv = erv; e.rd = erd;
        q.push_back(e);
    endtask

    task automatic strobe(input string req, input logic e_, input logic f_, input logic b_,
                          input logic c_, input int st, input logic ec, input logic ep);
        cyc(req, e_, f_, b_, c_, 1'b0, 5'd0, 4'd0, 16'h0, st, ec, ep, 1'b0, 16'h0);
    endtask

    task automatic wr(input string req, input logic [4:0] fn, input logic [3:0] ad,
                      input logic [15:0] wd, input int st, input logic ec, input logic ep);
        cyc(req, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, fn, ad, wd, st, ec, ep, 1'b0, 16'h0);
    endtask

    task automatic rd(input string req, input int st, input logic ec, input logic ep,
                      input logic erv, input logic [15:0] erd);
        cyc(req, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 4'd0, 16'h0, st, ec, ep, erv, erd);
    endtask

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        eoc = 0; fdone = 0; bdone = 0; clr = 0; cv = 0; func = '0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready", 16'(ready), 16'd1);
        chk("R1", "active", 16'({fast_act, bus_act}), 16'd0);
        chk("R1", "mode", 16'({comp, ped}), 16'd0);
        rst_n = 1'b1;
        rd("R1", 0, 0, 0, 1, 16'h0707);                  // default value after reset
        wr("R2", 5'd16, 4'd0, 16'h5A05, 0, 0, 0);
        rd("R2", 0, 0, 0, 1, 16'h5A05);                  // read returns written value
        wr("R2", 5'd16, 4'd1, 16'h0000, 0, 0, 0);        // wrong subaddress ignored
        wr("R2", 5'd17, 4'd0, 16'h0000, 0, 0, 0);        // wrong function ignored
        rd("R2", 0, 0, 0, 1, 16'h5A05);
        strobe("R4", 1, 0, 0, 0, 1, 0, 1);               // fast: comp=bit1=0 ped=bit2=1
        rd("R3", 1, 0, 1, 0, 16'h0);                     // read blocked while busy
        wr("R3", 5'd16, 4'd0, 16'h0000, 1, 0, 1);        // write blocked while busy
        strobe("R6", 1, 0, 0, 0, 1, 0, 1);               // eoc in fast ignored
        strobe("R6", 0, 0, 1, 0, 1, 0, 1);               // bus_done in fast ignored
        strobe("R6", 0, 1, 0, 0, 2, 0, 0);               // to bus; R8 comp masked by bus enable off
        strobe("R6", 0, 1, 0, 0, 2, 0, 0);               // fast_done in bus ignored
        strobe("R7", 0, 0, 1, 0, 0, 0, 0);
        rd("R3", 0, 0, 0, 1, 16'h5A05);                  // busy write left register unchanged
        wr("R5", 5'd16, 4'd0, 16'h0700, 0, 0, 0);
        strobe("R5", 1, 0, 0, 0, 2, 1, 1);               // R8 bus bits drive sequencer
        strobe("R7", 0, 0, 1, 0, 0, 0, 0);
        strobe("R7", 0, 0, 1, 0, 0, 0, 0);               // bus_done in ready ignored
        wr("R8", 5'd16, 4'd0, 16'h0201, 0, 0, 0);
        strobe("R8", 1, 0, 0, 0, 1, 0, 0);               // fast bits both 0
        strobe("R9", 0, 0, 0, 1, 0, 0, 0);               // clear aborts fast
        rd("R9", 0, 0, 0, 1, 16'h0707);
        strobe("R8", 1, 0, 0, 0, 1, 1, 1);
        strobe("R8", 0, 1, 0, 0, 2, 1, 1);
        strobe("R9", 0, 0, 1, 1, 0, 0, 0);               // clear aborts bus
        cyc("R9", 0, 0, 0, 1, 1, 5'd16, 4'd0, 16'h1234, 0, 0, 0, 0, 16'h0); // clear beats write
        rd("R9", 0, 0, 0, 1, 16'h0707);
        strobe("R9", 1, 0, 0, 1, 0, 0, 0);               // clear beats end of conversion
        strobe("R9", 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule